// File: doc/BRIEF.md
# Mask-Driven Bit Gather, Scatter and Split Unit

This unit rearranges the bits of a 64-bit source word under the control of an arbitrary 64-bit selection mask. There is no offset or length operand: every bit position the mask marks with a 1 takes part, wherever it lies. A 2-bit opcode picks one of three rearrangements.

Gather takes the marked source bits and packs them at the bottom of the result. Scatter spreads the lowest source bits out to the marked positions. Split keeps every source bit. It moves the marked bits to the top of the word and the unmarked bits to the bottom, and each group keeps its own bit order.

Requests arrive over a valid/ready handshake. The result appears in an output register one cycle after the request is accepted, with a valid flag. The consumer can stall the output register with its own ready input. While it does, the unit refuses new requests.

Top module: `bitsift_unit`

## Requirements
- R1: With opcode 2'b00 (gather), result bit k equals the source bit at the k-th lowest mask position holding a 1.
- R2: With opcode 2'b00, every result bit at an index of popcount(mask) or above is zero.
- R3: With opcode 2'b01 (scatter), the k-th lowest mask position holding a 1 receives source bit k, and every result bit where the mask is 0 is zero.
- R4: With opcode 2'b10 (split), the bits at mask-1 positions fill the top popcount(mask) result bits in ascending order. The bits at mask-0 positions fill the remaining low result bits in ascending order.
- R5: An all-zero mask gives a zero result for gather and scatter, and the unchanged source for split.
- R6: Opcode 2'b11 gives a zero result.
- R7: An accepted request (req_valid and req_ready high at a clock edge) makes res_valid high after that edge, with res_data holding its result.
- R8: While res_valid is high and res_ready is low, res_data and res_valid hold and req_ready is low. Otherwise req_ready is high.
- R9: After reset, res_valid is low, res_data is zero and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_op | input | 2 | Operation: 00 gather, 01 scatter, 10 split, 11 zero |
| req_src | input | 64 | Source word |
| req_mask | input | 64 | Selection mask |
| res_valid | output | 1 | Result register holds a result |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 64 | Result word |

## Verification
The embedded properties assume that req_op, req_src and req_mask are stable and meaningful only in the cycle a request is accepted. They also assume that the consumer's res_ready is an ordinary synchronous input that may toggle freely. The stimulus changes every input only at the falling clock edge. It randomises res_ready and req_valid independently, so requests arrive while the output is both free and stalled, and rejected requests carry values that must leave no trace. The mask patterns cover random values, all zeros, all ones and single bits, so the packing boundaries at popcount 0, 1 and 64 are all reached.

// File: rtl/bitsift_unit.sv
module bitsift_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [1:0]   req_op,
  input  logic [W-1:0] req_src,
  input  logic [W-1:0] req_mask,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_data
);

  localparam logic [1:0] OP_GATHER  = 2'b00;
  localparam logic [1:0] OP_SCATTER = 2'b01;
  localparam logic [1:0] OP_SPLIT   = 2'b10;

  function automatic logic [W-1:0] gather(input logic [W-1:0] s, input logic [W-1:0] m);
    logic [W-1:0] r;
    int k;
    r = '0;
    k = 0;
    for (int i = 0; i < W; i++)
      if (m[i]) begin
        r[k] = s[i];
        k++;
      end
    return r;
  endfunction

  function automatic logic [W-1:0] scatter(input logic [W-1:0] s, input logic [W-1:0] m);
    logic [W-1:0] r;
    int k;
    r = '0;
    k = 0;
    for (int i = 0; i < W; i++)
      if (m[i]) begin
        r[i] = s[k];
        k++;
      end
    return r;
  endfunction

  logic [W-1:0] lo_part, hi_part, split_res, next_res;
  int           ones;

  assign ones      = $countones(req_mask);
  assign lo_part   = gather(req_src, ~req_mask);
  assign hi_part   = (ones == 0) ? '0 : (gather(req_src, req_mask) << (W - ones));
  assign split_res = hi_part | lo_part;

  always_comb begin
    case (req_op)
      OP_GATHER:  next_res = gather(req_src, req_mask);
      OP_SCATTER: next_res = scatter(req_src, req_mask);
      OP_SPLIT:   next_res = split_res;
      default:    next_res = '0;
    endcase
  end

  logic accept;
  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_data  <= next_res;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_gather_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == OP_GATHER) |=> ((res_data >> $countones($past(req_mask))) == '0));

  p_scatter_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == OP_SCATTER) |=> ((res_data & ~$past(req_mask)) == '0));

  p_split_keeps_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == OP_SPLIT) |=> ($countones(res_data) == $countones($past(req_src))));

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == 2'b11) |=> (res_data == '0));

endmodule

// File: tb/test_bitsift_unit.sv
module test_bitsift_unit;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_op = 2'b00;
  logic [W-1:0] req_src = '0;
  logic [W-1:0] req_mask = '0;
  logic         res_valid;
  logic         res_ready = 1'b1;
  logic [W-1:0] res_data;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bitsift_unit #(.W(W)) i_bitsift_unit (.*);

  // behavioural reference model
  bit           m_valid;
  logic [W-1:0] m_data;
  string        m_tag;
  int           m_pc;
  bit           m_gather;

  function automatic logic [W-1:0] ref_op(input logic [1:0] op, input logic [W-1:0] s, input logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int sel[$];
    int rest[$];
    for (int i = 0; i < W; i++) if (m[i]) sel.push_back(i); else rest.push_back(i);
    case (op)
      2'b00: foreach (sel[j]) r[j] = s[sel[j]];
      2'b01: foreach (sel[j]) r[sel[j]] = s[j];
      2'b10: begin
        foreach (rest[j]) r[j] = s[rest[j]];
        foreach (sel[j]) r[W - sel.size() + j] = s[sel[j]];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare at negedge, then drive, then advance model to next posedge
  task automatic step(input bit v, input logic [1:0] op, input logic [W-1:0] s, input logic [W-1:0] m, input bit rr);
    bit exp_ready;
    @(negedge clk);
    check(res_valid == m_valid, "R7 res_valid", W'(res_valid), W'(m_valid));
    if (m_valid) begin
      check(res_data === m_data, m_tag, res_data, m_data);
      if (m_gather) check((res_data >> m_pc) == '0, "R2", res_data >> m_pc, '0);
    end
    req_valid = v; req_op = op; req_src = s; req_mask = m; res_ready = rr;
    #1;
    exp_ready = !m_valid || rr;
    check(req_ready == exp_ready, "R8 req_ready", W'(req_ready), W'(exp_ready));
    if (v && exp_ready) begin
      m_valid = 1;
      m_data = ref_op(op, s, m);
      m_pc = $countones(m);
      m_gather = (op == 2'b00);
      if (m == '0) m_tag = "R5";
      else case (op)
        2'b00: m_tag = "R1";
        2'b01: m_tag = "R3";
        2'b10: m_tag = "R4";
        default: m_tag = "R6";
      endcase
    end else if (rr) begin
      m_valid = 0;
    end else begin
      m_tag = "R8 hold";
    end
  endtask

  function automatic logic [W-1:0] pick_mask(input int k);
    case (k % 5)
      0: return '0;
      1: return '1;
      2: return W'(1) << $urandom_range(W - 1);
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_valid = 0; m_data = '0; m_tag = "R9"; m_pc = 0; m_gather = 0;
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R9 res_valid", W'(res_valid), '0);
    check(res_data == '0, "R9 res_data", res_data, '0);
    check(req_ready == 1'b1, "R9 req_ready", W'(req_ready), W'(1));
    rst_n = 1'b1;
    // directed: known values
    step(1, 2'b00, 64'h0000_0000_0000_F0F0, 64'h0000_0000_0000_FF00, 1);
    step(1, 2'b01, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_00F0, 1);
    step(1, 2'b10, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_000F, 1);
    step(1, 2'b10, 64'h1234_5678_9ABC_DEF0, 64'h0, 1);
    step(1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1);
    step(1, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1);
    step(1, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF, 1);
    step(1, 2'b10, 64'hA5A5_0000_FFFF_1234, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    // backpressure: result stalls, rejected requests must not change it
    step(1, 2'b00, 64'hDEAD_BEEF_0000_0001, 64'h8000_0000_0000_0001, 0);
    step(1, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    step(1, 2'b10, 64'h0, 64'h0, 0);
    step(0, 2'b00, 64'h0, 64'h0, 1);
    step(0, 2'b00, 64'h0, 64'h0, 1);
    // random traffic
    for (int i = 0; i < 3000; i++)
      step($urandom_range(3) != 0, 2'($urandom), {$urandom, $urandom}, pick_mask(i), $urandom_range(2) != 0);
    step(0, 2'b00, 64'h0, 64'h0, 1);
    step(0, 2'b00, 64'h0, 64'h0, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule